// File: doc/BRIEF.md
# Two-wire slave shift unit

This block is the bit-level front end of a two-wire (I2C-style) serial slave. Both bus lines are brought through synchronisers into the system-clock domain. A shift register collects the bits on the data line, and an edge counter ticks on every clock-line transition. A detector watches for start and stop conditions. The block drives two open-drain pull-down enables, one for each line. It makes no protocol decisions of its own. It stretches the clock line after a start and after each counter wrap, which hands the decision to a controller. The controller uses a four-address register port to read the received byte, load the byte to send, preload the counter and clear the event flags.

Acknowledge slots need no separate state machine. The controller writes 14 into the counter, and the counter wraps again after one more bit. A slave that is not addressed issues a park command. The unit then lets go of the clock line and ignores all bus activity until the next start.

The bus tracker has five states:
- IDLE: parked, or after a stop.
- ARMED: a start has been seen and the unit waits for the first clock fall.
- START_HOLD: the clock line is held low after the start.
- SHIFT: the unit counts edges and shifts bits.
- OVF_HOLD: the clock line is held low after a wrap.

Its transitions are:
- *start* (any state to ARMED).
- *stop* and *park* (any state to IDLE).
- *first fall* (ARMED to START_HOLD while the start flag is still set, else to SHIFT).
- *start release* (START_HOLD to SHIFT when the start flag is cleared).
- *wrap* (SHIFT to OVF_HOLD).
- *wrap release* (OVF_HOLD to SHIFT when the overflow flag is cleared).

Top module: `twowire_slave_shifter`

## Requirements
- R1: A falling data line while the clock line is high sets the start flag (address 2 bit 0). The clock line is not pulled until the clock line next falls.
- R2: The first clock fall after a start pulls the clock line low while the start flag is still set. Writing 1 to address 2 bit 0 clears that flag, releases the pull and zeroes the counter (address 1).
- R3: In SHIFT, each rising clock edge shifts the synchronised data-line level into bit 0 of the data register (address 0), with older bits moving toward bit 7. Nothing else changes that register except a write to it.
- R4: In SHIFT, the 4-bit counter adds one on each clock-line edge. The edge that takes it from 15 to 0 sets the overflow flag (address 2 bit 1) and pulls the clock line low until that flag is cleared by writing 1 to it.
- R5: With the counter preloaded to 14 through address 1, one more rising and falling clock edge wrap it to 0, set the overflow flag and pull the clock line again.
- R6: The data-line pull is active only while address 3 bit 0 is 1 and the output bit is 0. The output bit takes bit 7 of the data register on each data-register write and on each clock fall in SHIFT.
- R7: Writing 1 to address 3 bit 7 (park, reads back 0) releases any clock pull. Clock edges then neither shift nor count nor set flags until the next start.
- R8: A rising data line while the clock line is high sets the stop flag (address 2 bit 2) and releases any clock pull.
- R9: The interrupt output is high exactly when a set flag has its enable set. The enables are address 3 bit 1 (start), bit 2 (overflow) and bit 3 (stop).
- R10: A start in the middle of a byte behaves as a repeated start. It sets the start flag, and the unit holds the clock line at the next fall just as after a first start.
- R11: After reset, every register reads 0, both pulls are inactive and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line level as seen at the pin |
| sda_i | input | 1 | Data line level as seen at the pin |
| scl_pull_o | output | 1 | Pulls the clock line low when 1 |
| sda_pull_o | output | 1 | Pulls the data line low when 1 |
| reg_addr | input | 2 | Register select: 0 data, 1 counter, 2 flags, 3 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit data register, the derived 4-bit counter and two synchroniser stages. With these values one byte is exactly sixteen edges, so a whole byte and a wrap fit in each pass. The preload of 14 also lands exactly one bit before the wrap, which lets receive bytes, transmit bytes, wired-AND mixes and the acknowledge slot all run end to end. The two-stage synchroniser keeps the hold latency short enough that the bench's bus model can wait a fixed number of cycles after each line change and then observe the settled state.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START_HOLD,
        ST_SHIFT,
        ST_OVF_HOLD
    } twsl_state_e;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_CNT  = 2'd1;
    localparam logic [1:0] RA_FLAG = 2'd2;
    localparam logic [1:0] RA_CTRL = 2'd3;

    localparam int FB_START = 0;
    localparam int FB_OVF   = 1;
    localparam int FB_STOP  = 2;

    localparam int CB_OE       = 0;
    localparam int CB_IE_START = 1;
    localparam int CB_IE_OVF   = 2;
    localparam int CB_IE_STOP  = 3;
    localparam int CB_PARK     = 7;

endpackage

// File: rtl/twsl_sync.sv
module twsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= 1'b1;
                else        pipe[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= 1'b1;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/twsl_busmon.sv
module twsl_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // the clock line must be high in both samples around a data-line change
    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/twsl_fsm.sv
module twsl_fsm
    import twsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_evt,
    input  logic        stop_evt,
    input  logic        scl_fall,
    input  logic        park_cmd,
    input  logic        start_flag,
    input  logic        start_clr,
    input  logic        ovf_evt,
    input  logic        ovf_flag,
    input  logic        ovf_clr,
    output twsl_state_e state_q,
    output logic        shifting,
    output logic        scl_hold
);
    twsl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_ARMED;                       // start
        end else if (stop_evt || park_cmd) begin
            state_d = ST_IDLE;                        // stop / park
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_ARMED: begin
                    if (scl_fall)                     // first fall
                        state_d = (start_flag && !start_clr) ? ST_START_HOLD : ST_SHIFT;
                end
                ST_START_HOLD: begin
                    if (start_clr || !start_flag)     // start release
                        state_d = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (ovf_evt)                      // wrap
                        state_d = ST_OVF_HOLD;
                end
                ST_OVF_HOLD: begin
                    if (ovf_clr || !ovf_flag)         // wrap release
                        state_d = ST_SHIFT;
                end
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        scl_hold = 1'b0;
        shifting = 1'b0;
        unique case (state_q)
            ST_START_HOLD, ST_OVF_HOLD: scl_hold = 1'b1;
            ST_SHIFT:                   shifting = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/twsl_datapath.sv
module twsl_datapath
    import twsl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              shifting,
    output logic              irq,
    output logic              sda_pull,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              stop_flag,
    output logic              start_clr,
    output logic              ovf_clr,
    output logic              park_cmd,
    output logic              ovf_evt,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int CTRL_W = 4;

    logic              data_wr, cnt_wr, flag_wr, ctrl_wr, stop_clr, scl_edge;
    logic              out_bit;
    logic [CTRL_W-1:0] ctrl_q;

    assign data_wr  = reg_wr && (reg_addr == RA_DATA);
    assign cnt_wr   = reg_wr && (reg_addr == RA_CNT);
    assign flag_wr  = reg_wr && (reg_addr == RA_FLAG);
    assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
    assign start_clr = flag_wr && reg_wdata[FB_START];
    assign ovf_clr   = flag_wr && reg_wdata[FB_OVF];
    assign stop_clr  = flag_wr && reg_wdata[FB_STOP];
    assign park_cmd  = ctrl_wr && reg_wdata[CB_PARK];
    assign scl_edge  = scl_rise || scl_fall;

    assign ovf_evt = shifting && scl_edge && (&cnt_q) && !cnt_wr && !start_clr;

    // shift register: a write has priority over a sampled bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    data_q <= '0;
        else if (data_wr)              data_q <= reg_wdata;
        else if (shifting && scl_rise) data_q <= {data_q[DATA_W-2:0], sda_s};
    end

    // output bit moves only while the clock line is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    out_bit <= 1'b1;
        else if (data_wr)              out_bit <= reg_wdata[DATA_W-1];
        else if (shifting && scl_fall) out_bit <= data_q[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (cnt_wr)               cnt_q <= reg_wdata[CNT_W-1:0];
        else if (start_clr)            cnt_q <= '0;
        else if (shifting && scl_edge) cnt_q <= cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            ovf_flag   <= 1'b0;
            stop_flag  <= 1'b0;
        end else begin
            if (start_evt)      start_flag <= 1'b1;
            else if (start_clr) start_flag <= 1'b0;
            if (ovf_evt)        ovf_flag   <= 1'b1;
            else if (ovf_clr)   ovf_flag   <= 1'b0;
            if (stop_evt)       stop_flag  <= 1'b1;
            else if (stop_clr)  stop_flag  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    assign sda_pull = ctrl_q[CB_OE] && !out_bit;
    assign irq = (start_flag && ctrl_q[CB_IE_START]) ||
                 (ovf_flag   && ctrl_q[CB_IE_OVF])   ||
                 (stop_flag  && ctrl_q[CB_IE_STOP]);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_DATA: reg_rdata = data_q;
            RA_CNT:  reg_rdata[CNT_W-1:0] = cnt_q;
            RA_FLAG: begin
                reg_rdata[FB_START] = start_flag;
                reg_rdata[FB_OVF]   = ovf_flag;
                reg_rdata[FB_STOP]  = stop_flag;
            end
            RA_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/twowire_slave_shifter.sv
module twowire_slave_shifter
    import twsl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_o,
    output logic              sda_pull_o,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(2 * DATA_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic shifting, scl_hold;
    logic start_flag, ovf_flag, stop_flag, start_clr, ovf_clr, park_cmd, ovf_evt;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    twsl_state_e       state_q;

    twsl_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );
    twsl_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    twsl_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twsl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall),
        .park_cmd(park_cmd), .start_flag(start_flag), .start_clr(start_clr),
        .ovf_evt(ovf_evt), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
        .state_q(state_q), .shifting(shifting), .scl_hold(scl_hold)
    );

    twsl_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .shifting(shifting),
        .irq(irq_o), .sda_pull(sda_pull_o),
        .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
        .start_clr(start_clr), .ovf_clr(ovf_clr), .park_cmd(park_cmd),
        .ovf_evt(ovf_evt), .cnt_q(cnt_q), .data_q(data_q)
    );

    assign scl_pull_o = scl_hold;
endmodule

// File: rtl/twsl_chk.sv
module twsl_chk
    import twsl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              scl_pull_o,
    input logic              irq_o,
    input twsl_state_e       state_q,
    input logic              start_flag,
    input logic              ovf_flag,
    input logic              stop_flag,
    input logic              park_cmd,
    input logic              start_evt,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] data_q
);
    // R1
    start_no_early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> !scl_pull_o);

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(start_flag) && $past(state_q == ST_START_HOLD)) |-> !scl_pull_o);

    // R3
    data_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise && !(reg_wr && reg_addr == RA_DATA)) |=> $stable(data_q));

    // R4
    cnt_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise && !scl_fall && !reg_wr) |=> $stable(cnt_q));

    // R4
    wrap_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && !$past(park_cmd)) |-> scl_pull_o);

    // R7
    park_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (park_cmd && !start_evt) |=> !scl_pull_o);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> !scl_pull_o);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_flag && !ovf_flag && !stop_flag) |-> !irq_o);
endmodule

bind twowire_slave_shifter twsl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .scl_pull_o(scl_pull_o), .irq_o(irq_o), .state_q(state_q),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .stop_flag(stop_flag),
    .park_cmd(park_cmd), .start_evt(start_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .cnt_q(cnt_q), .data_q(data_q)
);

// File: tb/sim_twowire_slave_shifter.sv
module sim_twowire_slave_shifter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       scl_pull, sda_pull, irq;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    wire        scl_line = scl_m & ~scl_pull;
    wire        sda_line = sda_m & ~sda_pull;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    twowire_slave_shifter u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq)
    );

    // fields: rx byte from master [23:16], slave tx byte [15:8], output enable [0]
    localparam logic [23:0] VEC [4] = '{24'hA5_FF_00, 24'h3C_00_00, 24'hFF_96_01, 24'hF0_5A_01};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bitclk(input logic b, output logic s);
        sda_m = b; settle();
        scl_m = 1'b1; settle();
        s = sda_line;
        scl_m = 1'b0; settle();
    endtask

    task automatic do_start();
        sda_m = 1'b1; settle();
        scl_m = 1'b1; settle();
        sda_m = 1'b0; settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv, rx, tx, expv, got;
        logic       oe, s;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv);
            chk("R11 register after reset", rv, 0);
        end
        chk("R11 pulls after reset", {scl_pull, sda_pull}, 0);
        chk("R11 irq after reset", irq, 0);

        // table of bytes, each with slave acknowledge and stop
        for (int i = 0; i < 4; i++) begin
            rx = VEC[i][23:16]; tx = VEC[i][15:8]; oe = VEC[i][0];
            expv = rx & (oe ? tx : 8'hFF);
            do_start();
            rd(2'd2, rv);
            chk("R1 start flag", rv[0], 1);
            chk("R1 no hold before fall", scl_pull, 0);
            scl_m = 1'b0; settle();
            chk("R2 hold after first fall", scl_pull, 1);
            wr(2'd0, tx);
            wr(2'd3, {7'd0, oe});
            wr(2'd2, 8'h01);
            settle();
            chk("R2 hold released", scl_pull, 0);
            rd(2'd1, rv);
            chk("R2 counter zeroed", rv, 0);
            for (int b = 7; b >= 0; b--) begin
                bitclk(rx[b], s);
                got[b] = s;
            end
            chk("R6 data line bits", got, expv);
            rd(2'd0, rv);
            chk("R3 received byte", rv, expv);
            rd(2'd2, rv);
            chk("R4 overflow flag", rv[1], 1);
            chk("R4 hold on wrap", scl_pull, 1);
            // acknowledge slot
            sda_m = 1'b1;
            wr(2'd1, 8'd14);
            wr(2'd0, 8'h00);
            wr(2'd3, 8'h01);
            wr(2'd2, 8'h02);
            settle();
            scl_m = 1'b1; settle();
            chk("R6 ack pulls data line", sda_line, 0);
            scl_m = 1'b0; settle();
            chk("R5 hold after ack bit", scl_pull, 1);
            rd(2'd1, rv);
            chk("R5 counter wrapped", rv, 0);
            rd(2'd2, rv);
            chk("R5 overflow flag", rv[1], 1);
            // stop
            wr(2'd3, 8'h00);
            wr(2'd2, 8'h02);
            sda_m = 1'b0; settle();
            scl_m = 1'b1; settle();
            sda_m = 1'b1; settle();
            rd(2'd2, rv);
            chk("R8 stop flag", rv[2], 1);
            chk("R8 clock released", scl_pull, 0);
            wr(2'd2, 8'h04);
        end

        // R9 interrupt masking
        wr(2'd3, 8'h02);
        do_start();
        chk("R9 start irq enabled", irq, 1);
        wr(2'd2, 8'h01);
        settle();
        chk("R9 irq after clear", irq, 0);
        sda_m = 1'b1; settle();
        rd(2'd2, rv);
        chk("R9 stop flag set", rv[2], 1);
        chk("R9 stop irq masked", irq, 0);
        wr(2'd3, 8'h08);
        chk("R9 stop irq enabled", irq, 1);
        wr(2'd2, 8'h04);
        wr(2'd3, 8'h00);
        chk("R9 irq after stop clear", irq, 0);

        // R10 repeated start in the middle of a byte
        do_start();
        scl_m = 1'b0; settle();
        wr(2'd2, 8'h01);
        bitclk(1'b1, s); bitclk(1'b0, s); bitclk(1'b1, s);
        rd(2'd1, rv);
        chk("R4 counter after three bits", rv, 6);
        sda_m = 1'b1; settle();
        scl_m = 1'b1; settle();
        sda_m = 1'b0; settle();
        rd(2'd2, rv);
        chk("R10 repeated start flag", rv[0], 1);
        chk("R10 no hold while high", scl_pull, 0);
        scl_m = 1'b0; settle();
        chk("R10 hold after fall", scl_pull, 1);
        wr(2'd2, 8'h01);
        settle();
        rd(2'd1, rv);
        chk("R10 counter zeroed", rv, 0);

        // R7 park after a full byte
        for (int b = 0; b < 8; b++) bitclk(b[0], s);
        chk("R7 hold before park", scl_pull, 1);
        rd(2'd0, rv);
        chk("R7 byte before park", rv, 8'h55);
        wr(2'd3, 8'h80);
        settle();
        chk("R7 park releases clock", scl_pull, 0);
        rd(2'd3, rv);
        chk("R7 park reads zero", rv, 0);
        wr(2'd2, 8'h02);
        for (int b = 0; b < 5; b++) bitclk(1'b0, s);
        rd(2'd1, rv);
        chk("R7 counter frozen", rv, 0);
        rd(2'd0, rv);
        chk("R7 data frozen", rv, 8'h55);
        rd(2'd2, rv);
        chk("R7 no flags while parked", rv, 0);
        chk("R7 clock free while parked", scl_pull, 0);
        do_start();
        rd(2'd2, rv);
        chk("R7 next start seen", rv[0], 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule